// File: doc/BRIEF.md
# Prescaled Timer Counter

This block is a 16-bit up-counter that advances on a one-cycle enable pulse from a power-of-two prescaler. The prescaler divides the system clock by 1 to 64 and runs on the same clock as everything else. Software drives the block through one 8-bit control/status register. That register holds:

- a wrap flag,
- a wrap interrupt enable,
- a halt bit,
- a self-clearing counter-clear bit,
- a three-bit divider select.

The live count is visible at all times on a plain output port. The interrupt line is high while the wrap flag and its enable are both set.

The register port is a plain write strobe with write data and a combinational read value. No stream data crosses the block's edge, so the block has no valid/ready handshake and no back-pressure. A write is taken on every clock edge where `ctl_wr` is high.

After reset the block is halted with divide-by-1 selected. Software typically writes the divider code with the clear bit set and the halt bit low. The counter then starts from zero.

Control register layout:

| Bit | Field |
|---|---|
| 7 | wrap flag |
| 6 | interrupt enable |
| 5 | halt |
| 4 | clear (write-only, reads 0) |
| 3 | reserved (reads 0) |
| 2:0 | divider select |

Top module: `tmr_prescaled_timer`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x20 (halt set, all else 0), `cnt_o` is 0, and `irq_o` is 0. The count stays 0 while no write occurs.
- R2: While bit 5 (halt) is 1, neither the count nor the prescaler advances. Once bit 5 is written 0, counting resumes from the held value.
- R3: A write with bit 4 set makes the count 0 and the prescaler phase 0 at that clock edge, and counting restarts from zero. The clear itself leaves the wrap flag unchanged.
- R4: Bit 4 reads back as 0 at all times, and bit 3 also reads 0.
- R5: A write with both bit 5 and bit 4 set leaves the count held at 0.
- R6: With divider select code k in 0..6 and the block running, the count advances once every 2^k clocks. Starting from a clear, after n running clocks the count equals floor(n / 2^k).
- R7: Divider code 7 never advances the count. The control fields remain writable and readable under this code.
- R8: When a count step takes the value from 0xFFFF to 0x0000, the wrap flag (bit 7) becomes 1.
- R9: Writing bit 7 as 0 clears the wrap flag, and writing it as 1 has no effect. If a wrap and a clearing write fall on the same edge, the flag ends up 1.
- R10: `irq_o` is 1 exactly when the wrap flag and bit 6 (interrupt enable) are both 1.
- R11: A write that changes the divider code without setting bit 4 keeps the current count. The new code takes effect on the next prescaler tick against the running prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the prescaler divides this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Current control register value |
| cnt_o | output | 16 | Current counter value |
| irq_o | output | 1 | Wrap interrupt request |

## Verification
The divider is swept over every valid code. Each code starts from a clear, and the count is compared on every clock against floor(n / 2^k) for up to four full divider periods. This separates an off-by-one tap, a wrong divider phase after a clear, and a swapped code.

Separate patterns cover the following:
- halting and resuming mid-run;
- halt and clear written together;
- the invalid code;
- a divider change while running, where the expected count depends on the retained prescaler phase.

A single full wrap at divide-by-1 is timed so that a flag-clearing write lands on the wrap edge. This checks that the set takes priority, and the flag-write and enable combinations that follow check the interrupt gating.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W   = 8;
  localparam int SEL_W   = 3;
  localparam int FLAG_B  = 7;
  localparam int IE_B    = 6;
  localparam int HALT_B  = 5;
  localparam int CLR_B   = 4;
  localparam int RSV_B   = 3;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic             halt;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{flag: 1'b0, ie: 1'b0, halt: 1'b1, sel: '0};
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W   = 3,
  parameter int NUM_DIV = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W   = (NUM_DIV > 1) ? NUM_DIV - 1 : 1;
  localparam int SEL_LEN = 1 << SEL_W;

  logic [PRE_W-1:0]   phase_q;
  logic [SEL_LEN-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= phase_q + 1'b1;
  end

  // taps[k] pulses once every 2^k clocks; codes at or above NUM_DIV never tick
  genvar gi;
  generate
    for (gi = 0; gi < SEL_LEN; gi++) begin : g_tap
      if (gi == 0) begin : g_div1
        assign taps[gi] = 1'b1;
      end else if (gi < NUM_DIV) begin : g_divk
        assign taps[gi] = &phase_q[gi-1:0];
      end else begin : g_none
        assign taps[gi] = 1'b0;
      end
    end
  endgenerate

  assign tick = run & taps[sel];

  assert_div1_every_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel == '0) |-> tick);
  assert_invalid_code_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NUM_DIV) |-> !tick);
  assert_halt_freezes_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign wrap = step & ~restart & (cnt_q == CNT_MAX);

  assert_clear_gives_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             wrap,
  output logic [CTL_W-1:0] rdata,
  output logic             halt,
  output logic [SEL_W-1:0] sel,
  output logic             restart,
  output logic             irq
);
  ctl_t ctl_q;
  logic unused_rsv;

  assign unused_rsv = wdata[RSV_B];
  assign restart    = wr & wdata[CLR_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else begin
      if (wr) begin
        ctl_q.ie   <= wdata[IE_B];
        ctl_q.halt <= wdata[HALT_B];
        ctl_q.sel  <= wdata[SEL_W-1:0];
      end
      // a wrap on the same edge beats a software clear
      if (wrap)                     ctl_q.flag <= 1'b1;
      else if (wr && !wdata[FLAG_B]) ctl_q.flag <= 1'b0;
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[FLAG_B]      = ctl_q.flag;
    rdata[IE_B]        = ctl_q.ie;
    rdata[HALT_B]      = ctl_q.halt;
    rdata[SEL_W-1:0]   = ctl_q.sel;
  end

  assign halt = ctl_q.halt;
  assign sel  = ctl_q.sel;
  assign irq  = ctl_q.flag & ctl_q.ie;

  assert_wrap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ctl_q.flag);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[FLAG_B] && !wrap) |=> !ctl_q.flag);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.flag && !(wr && !wdata[FLAG_B])) |=> ctl_q.flag);
endmodule

// File: rtl/tmr_prescaled_timer.sv
module tmr_prescaled_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_DIV = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             halt, restart, tick, wrap;
  logic [SEL_W-1:0] sel;

  tmr_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctl_wr),
    .wdata   (ctl_wdata),
    .wrap    (wrap),
    .rdata   (ctl_rdata),
    .halt    (halt),
    .sel     (sel),
    .restart (restart),
    .irq     (irq_o)
  );

  tmr_prescaler #(.SEL_W(SEL_W), .NUM_DIV(NUM_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (~halt),
    .restart (restart),
    .sel     (sel),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (tick),
    .restart (restart),
    .cnt     (cnt_o),
    .wrap    (wrap)
  );

  assert_halt_holds_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !restart) |=> $stable(cnt_o));
  assert_rollover_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_o) == CNT_MAX && cnt_o == '0 && !$past(restart)) |-> ctl_rdata[FLAG_B]);
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ctl_rdata[IE_B] && ctl_rdata[FLAG_B]));
  assert_clear_bit_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_wr && ctl_wdata[CLR_B]) |-> !ctl_rdata[CLR_B]);
endmodule

// File: tb/tmr_prescaled_timer_bench.sv
module tmr_prescaled_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [7:0]  ctl_rdata;
  logic [15:0] cnt_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_prescaled_timer u_tmr_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_o(cnt_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 ctl", {24'h0, ctl_rdata}, 32'h20);
    chk("R1 cnt", {16'h0, cnt_o}, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    idle(20);
    chk("R1 halted cnt", {16'h0, cnt_o}, 32'h0);

    // R6 divider sweep: count == n >> k after n running clocks from a clear
    for (int k = 0; k < 7; k++) begin
      wr(8'h10 | 8'(k));
      chk("R4 clr reads 0", {24'h0, ctl_rdata}, 32'(k));
      for (int n = 1; n <= (4 << k); n++) begin
        @(negedge clk);
        chk("R6 div count", {16'h0, cnt_o}, 32'(n >> k));
      end
    end

    // R2 halt and resume
    wr(8'h10); idle(5);
    chk("R2 pre-halt", {16'h0, cnt_o}, 32'd5);
    wr(8'h20);
    chk("R2 halt edge", {16'h0, cnt_o}, 32'd6);
    idle(10);
    chk("R2 held", {16'h0, cnt_o}, 32'd6);
    wr(8'h00); idle(3);
    chk("R2 resumed", {16'h0, cnt_o}, 32'd9);

    // R5 halt+clear together
    wr(8'h30); idle(8);
    chk("R5 held zero", {16'h0, cnt_o}, 32'd0);
    chk("R5 ctl", {24'h0, ctl_rdata}, 32'h20);

    // R7 invalid code
    wr(8'h17); idle(100);
    chk("R7 no advance", {16'h0, cnt_o}, 32'd0);
    chk("R7 ctl read", {24'h0, ctl_rdata}, 32'h07);
    wr(8'h03);
    chk("R7 ctl rewrite", {24'h0, ctl_rdata}, 32'h03);

    // R11 divider change keeps count and phase
    wr(8'h10); idle(10);
    chk("R11 before", {16'h0, cnt_o}, 32'd10);
    wr(8'h01);
    chk("R11 kept", {16'h0, cnt_o}, 32'd11);
    idle(20);
    chk("R11 new rate", {16'h0, cnt_o}, 32'd21);

    // R8 / R9 / R10 / R3 wrap path
    wr(8'h50); idle(65535);
    chk("R8 at max", {16'h0, cnt_o}, 32'hFFFF);
    chk("R8 flag low", {24'h0, ctl_rdata}, 32'h40);
    wr(8'h40);  // clearing write lands on the wrap edge
    chk("R8 wrapped", {16'h0, cnt_o}, 32'h0);
    chk("R9 set wins", {24'h0, ctl_rdata}, 32'hC0);
    chk("R10 irq on", {31'h0, irq_o}, 32'h1);
    idle(4);
    wr(8'hD0);
    chk("R3 cleared", {16'h0, cnt_o}, 32'h0);
    chk("R3 flag kept", {24'h0, ctl_rdata}, 32'hC0);
    wr(8'h80);
    chk("R10 ie off ctl", {24'h0, ctl_rdata}, 32'h80);
    chk("R10 irq off", {31'h0, irq_o}, 32'h0);
    wr(8'hC0);
    chk("R10 irq back", {31'h0, irq_o}, 32'h1);
    wr(8'h40);
    chk("R9 flag cleared", {24'h0, ctl_rdata}, 32'h40);
    chk("R9 irq low", {31'h0, irq_o}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule